// File: doc/BRIEF.md
# Auxiliary Event Timestamp Capture

This block records the value of a 64-bit free-running system time bus at the moment an external, asynchronous trigger line rises. The trigger is treated as input-only. It passes through a flip-flop synchronizer and a rising-edge detector before it has any effect. A capture happens only while the slave-mode control input is high.

The block holds one captured timestamp at a time. A capture sets a sticky event flag, and while that flag is set the captured value is frozen. Software reads the timestamp as two 32-bit words. It then acknowledges the event by writing 1 to the flag bit, which re-arms the block. The next capture needs a fresh rising edge of the trigger that arrives after the clear. A trigger that is still held high does not count.

Access is through a simple single-cycle register port. The write strobe, address and data are sampled on the clock edge. Read data follows the address combinationally. The time counter, interrupt routing and pin direction control are outside this block.

Top module: `aux_snap_capture`

## Requirements
- R1: After reset, the event register (offset 0x20), the low snapshot word (0x30) and the high snapshot word (0x34) all read zero.
- R2: While slave_mode_i is high and the event flag is clear, a rising edge on trig_i is captured. Assume the edge is set up before clock edge k+1. Then at edge k+3, sys_time_i[31:0] (as presented before that edge) is loaded into word 0x30 and sys_time_i[63:32] into word 0x34, and bit 0 of word 0x20 becomes 1. The flag still reads 0 before edge k+3.
- R3: A rising edge that is synchronized while slave_mode_i is low captures nothing. Raising slave_mode_i later, while trig_i stays high, also captures nothing.
- R4: While the event flag is set, further trigger edges leave both snapshot words unchanged.
- R5: A write to offset 0x20 with data bit 0 = 1 clears the flag on that clock edge. A write to 0x20 with bit 0 = 0 leaves the flag unchanged.
- R6: After a clear, a trigger that is still high does not cause a capture. A new low-to-high transition is needed.
- R7: If a clearing write and a qualifying synchronized rising edge land on the same clock edge, the clear wins. The flag ends at 0, the snapshot is unchanged, and that edge is lost.
- R8: Both snapshot words are loaded from a single 64-bit sample on one clock edge, so the low and high words always belong to the same time value, including across a carry out of the low word.
- R9: Reads of undefined offsets return zero, and bits 31:1 of the event word read zero. Writes to offsets 0x30 and 0x34 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Asynchronous trigger line |
| slave_mode_i | input | 1 | Capture enable (slave mode) |
| sys_time_i | input | 64 | Free-running system time |
| reg_addr_i | input | ADDR_W (8) | Register byte address |
| reg_wr_i | input | 1 | Write strobe, sampled on clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |

## Verification
The hardest case to reach from the ports is the collision between a clearing write and a synchronized rising edge on the same clock edge. The trigger is seen at the edge detector only two clocks after it changes, so the write has to be placed exactly in that cycle. The bench drives the trigger on a known falling edge, counts two clocks, and asserts the write for the third edge. It also checks, in the same cycle, that the flag has not yet moved. Randomized rounds mix mode, pre-clears, writes of zero, writes to read-only words and collisions, while the time bus changes to a new random value every cycle.

// File: rtl/aux_snap_pkg.sv
package aux_snap_pkg;
  localparam int unsigned TIME_W   = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OFF_EVT  = 32'h20;
  localparam int unsigned OFF_LO   = 32'h30;
  localparam int unsigned OFF_HI   = 32'h34;
  localparam int unsigned FLAG_BIT = 0;
endpackage

// File: rtl/aux_snap_sync.sv
module aux_snap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= 1'b0;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/aux_snap_edge.sv
module aux_snap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/aux_snap_core.sv
module aux_snap_core #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              slave_mode_i,
  input  logic              clr_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              flag_o,
  output logic [TIME_W-1:0] snap_o
);
  logic cap;

  // clear beats a same-cycle edge; a held flag locks the snapshot
  assign cap = rise_i & slave_mode_i & ~flag_o & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (cap)   flag_o <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)  snap_o <= '0;
    else if (cap) snap_o <= time_i;
endmodule

// File: rtl/aux_snap_regs.sv
module aux_snap_regs
  import aux_snap_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              flag_i,
  input  logic [TIME_W-1:0] snap_i,
  output logic              clr_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(OFF_EVT);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFF_LO);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFF_HI);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign clr_o = wr_i && (addr_i == A_EVT) && wdata_i[FLAG_BIT];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_EVT:   rdata_o[FLAG_BIT] = flag_i;
      A_LO:    rdata_o = snap_i[WORD_W-1:0];
      A_HI:    rdata_o = snap_i[TIME_W-1:WORD_W];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/aux_snap_capture.sv
module aux_snap_capture
  import aux_snap_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              slave_mode_i,
  input  logic [63:0]       sys_time_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  logic              trig_sync;
  logic              trig_rise;
  logic              clr_req;
  logic              snap_flag;
  logic [TIME_W-1:0] snap_q;

  aux_snap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_i),
    .q_o   (trig_sync)
  );

  aux_snap_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (trig_sync),
    .rise_o(trig_rise)
  );

  aux_snap_core #(.TIME_W(TIME_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (trig_rise),
    .slave_mode_i(slave_mode_i),
    .clr_i       (clr_req),
    .time_i      (sys_time_i),
    .flag_o      (snap_flag),
    .snap_o      (snap_q)
  );

  aux_snap_regs #(.ADDR_W(ADDR_W)) u_regs (
    .addr_i (reg_addr_i),
    .wr_i   (reg_wr_i),
    .wdata_i(reg_wdata_i),
    .flag_i (snap_flag),
    .snap_i (snap_q),
    .clr_o  (clr_req),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/aux_snap_capture_chk.sv
module aux_snap_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        slave_mode_i,
  input logic [63:0] sys_time_i,
  input logic        rise,
  input logic        clr,
  input logic        flag,
  input logic [63:0] snap
);
  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && slave_mode_i && !flag && !clr |=> flag && (snap == $past(sys_time_i)));

  p_master_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_mode_i |=> $stable(snap));

  p_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag |=> $stable(snap));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !flag);

  p_needs_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(rise));

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && rise |=> !flag && $stable(snap));
endmodule

bind aux_snap_capture aux_snap_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slave_mode_i(slave_mode_i),
  .sys_time_i  (sys_time_i),
  .rise        (trig_rise),
  .clr         (clr_req),
  .flag        (snap_flag),
  .snap        (snap_q)
);

// File: tb/aux_snap_capture_bench.sv
`timescale 1ns/1ps
module aux_snap_capture_bench;
  localparam logic [7:0] A_EVT = 8'h20;
  localparam logic [7:0] A_LO  = 8'h30;
  localparam logic [7:0] A_HI  = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        mode = 1'b0;
  logic [63:0] sys_time = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  logic        exp_flag = 1'b0;
  logic [63:0] exp_snap = '0;

  always #4 clk = ~clk;

  aux_snap_capture u_aux_snap_capture (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .trig_i      (trig),
    .slave_mode_i(mode),
    .sys_time_i  (sys_time),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sys_time = {$urandom, $urandom};
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    rd(A_EVT, d); chk(req, d, {31'b0, exp_flag});
    rd(A_LO, d);  chk(req, d, exp_snap[31:0]);
    rd(A_HI, d);  chk(req, d, exp_snap[63:32]);
  endtask

  task automatic idle(input int n);
    trig = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (a == A_EVT && d[0]) exp_flag = 1'b0;
  endtask

  // trigger rises before edge k+1; capture lands on edge k+3
  task automatic pulse(input bit collide, input string req);
    logic [63:0] t2;
    logic [31:0] d;
    @(negedge clk);
    trig = 1'b1;
    sys_time = {$urandom, $urandom};
    tick();
    tick();
    t2 = sys_time;
    rd(A_EVT, d);
    chk({req, " R2 latency"}, d, {31'b0, exp_flag});
    if (collide) begin
      wr = 1'b1; addr = A_EVT; wdata = 32'h1;
    end
    tick();
    wr = 1'b0;
    if (collide) exp_flag = 1'b0;
    else if (mode && !exp_flag) begin
      exp_snap = t2;
      exp_flag = 1'b1;
    end
    check_all(req);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R2 basic capture in slave mode
    mode = 1'b1;
    idle(4);
    pulse(1'b0, "R2 capture");

    // R4 locked while flag set
    idle(4);
    pulse(1'b0, "R4 locked");

    // R5 write 0 no effect, write 1 clears
    wr_reg(A_EVT, 32'hFFFF_FFFE);
    check_all("R5 write0");
    // R6 clear while trigger still high: no capture
    trig = 1'b1;
    wr_reg(A_EVT, 32'h1);
    for (int i = 0; i < 6; i++) tick();
    check_all("R6 held level");
    idle(4);
    pulse(1'b0, "R6 fresh edge");

    // R9 writes to snapshot words ignored, undefined offsets read zero
    wr_reg(A_LO, 32'hDEAD_BEEF);
    wr_reg(A_HI, 32'hCAFE_F00D);
    check_all("R9 ro write");
    rd(8'h24, d); chk("R9 undef 0x24", d, 32'h0);
    rd(8'h00, d); chk("R9 undef 0x00", d, 32'h0);
    rd(8'h38, d); chk("R9 undef 0x38", d, 32'h0);

    // R3 edge in master mode, then mode rises with trigger still high
    wr_reg(A_EVT, 32'h1);
    mode = 1'b0;
    idle(4);
    pulse(1'b0, "R3 master edge");
    mode = 1'b1;
    for (int i = 0; i < 6; i++) tick();
    check_all("R3 late mode");

    // R7 clear collides with qualifying edge
    idle(4);
    pulse(1'b1, "R7 collide");
    for (int i = 0; i < 6; i++) tick();
    check_all("R7 edge lost");

    // R8 carry across the low word boundary
    idle(4);
    @(negedge clk);
    trig = 1'b1;
    sys_time = 64'h0000_0004_FFFF_FFFE;
    @(negedge clk); sys_time = sys_time + 1;
    @(negedge clk); sys_time = sys_time + 1;
    @(negedge clk); sys_time = sys_time + 1;
    exp_snap = 64'h0000_0005_0000_0000;
    exp_flag = 1'b1;
    check_all("R8 coherent carry");

    // randomized rounds
    for (int it = 0; it < 60; it++) begin
      logic r_clr;
      logic r_col;
      mode  = ($urandom_range(3) != 0);
      r_clr = $urandom_range(1);
      r_col = ($urandom_range(5) == 0);
      idle(4);
      if (r_clr) wr_reg(A_EVT, 32'h1);
      if ($urandom_range(1)) wr_reg(A_EVT, {$urandom, 1'b0} >> 1 << 1);
      if ($urandom_range(3) == 0) wr_reg(($urandom_range(1) != 0) ? A_LO : A_HI, $urandom);
      pulse(r_col, r_col ? "R7 random" : "R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule